// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers the interrupt sources of a small 8-bit processor core and turns them into one request line for the core's sequencer. Each source owns a flag bit and an enable bit. The sources fall into two groups. The core group covers a timer overflow, an external edge and a port-change detector. The peripheral group covers up to sixteen sources spread over two flag registers. A master enable gates every request. A second enable must also be set before any peripheral source can raise a request.

A flag is set by its event whether or not it is enabled, and only software can clear it. Software reaches the flags and enables through a small register port. Writes take effect at the clock edge. Read data is registered: it is valid one cycle after the address is presented.

The port-change detector compares four upper port pins against a reference latch. While the pins differ from the latch, the detector sets its flag again on every cycle. A port-read strobe loads the pins into the latch, which ends the mismatch so that the flag can then be cleared. When the core acknowledges a request, the master enable is cleared in that cycle, which blocks nested requests until software sets it again.

The event sources and the vector fetch lie outside the block. Events arrive as single-cycle pulses and the acknowledge arrives as a pulse.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While and after reset, every register reads 0x00 and `irq_req` is low.
- R2: An event pulse sets its flag at the next clock edge, regardless of its enable bit and of the master enable. In the core register (address 0), bit 2 is the timer overflow flag, bit 1 the external edge flag and bit 0 the port-change flag. Peripheral event bit n sets bit n of flag register 1 (address 1) or flag register 2 (address 2).
- R3: `irq_req` is high exactly when the master enable (address 0, bit 7) is set and some source has both its flag and its enable set. Peripheral sources are further subject to R4. Core enables are bit 5 for the timer, bit 4 for the external edge and bit 3 for the port change.
- R4: A peripheral source raises `irq_req` only when the peripheral group enable (address 0, bit 6) is also set. Peripheral enables live at address 3 (for flag register 1) and address 4 (for flag register 2), bit for bit.
- R5: The port-change flag sets whenever the four port pins differ from the reference latch. A write that clears the flag is overridden on the next edge while the mismatch persists.
- R6: A `port_rd` pulse loads the pins into the reference latch. After that, a clearing write makes the flag stay clear until the pins change again.
- R7: A flag that is set stays set until software writes a 0 to it. Time and further events do not clear it.
- R8: Flag register 2 and its enable register implement only bits 6, 4, 3 and 0 (mask 0x59). The other bits read as zero, whether they are written or pulsed by an event.
- R9: An `irq_ack` pulse clears the master enable at that clock edge. This holds even when a write setting the master enable falls in the same cycle, and the other bits of that write still land.
- R10: When an event and a software write clearing the same flag fall in the same cycle, the flag ends up set.
- R11: `reg_rdata` shows the register selected by `reg_addr` one clock after the address is presented. Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| tmr_ovf_evt | input | 1 | Timer overflow event pulse |
| ext_edge_evt | input | 1 | External edge event pulse |
| port_pins | input | 4 | Upper port pins watched for change (synchronous) |
| port_rd | input | 1 | Port read strobe, loads the reference latch |
| per1_evt | input | 8 | Event pulses for peripheral flag register 1 |
| per2_evt | input | 8 | Event pulses for peripheral flag register 2 |
| irq_ack | input | 1 | Interrupt acknowledge pulse from the core |
| irq_req | output | 1 | Interrupt request to the sequencer |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a hardware event and a software write that clears the same flag. The bench pulses the timer event in the very cycle that a zero is written to the core register. It expects the readback to keep the flag set.

The second pair is an acknowledge and a write that sets the master enable. The bench drives both in one cycle. It expects the master enable to read back as zero, the other written bits to be present, and `irq_req` to stay low. The persistent port mismatch is a related case. In that case a clearing write races a flag that is re-set every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CORE_SRC = 3;

  localparam logic [ADDR_W-1:0] A_CORE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PFLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_PEN   = 3'd3;

  localparam int B_GIE  = 7;
  localparam int B_PEIE = 6;
  localparam int B_EN_HI = 5;
  localparam int B_EN_LO = 3;
  localparam int B_FL_HI = 2;
  localparam int B_FL_LO = 0;
endpackage

// File: rtl/irq_port_change.sv
module irq_port_change #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic         rd_strobe,
  output logic [W-1:0] ref_q,
  output logic         mismatch
);
  always_ff @(posedge clk) begin
    if (rst) ref_q <= '0;
    else if (rd_strobe) ref_q <= pins;
  end

  assign mismatch = |(pins ^ ref_q);
endmodule

// File: rtl/irq_core_reg.sv
module irq_core_reg
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                ack,
  input  logic [CORE_SRC-1:0] evt,
  output logic                gie,
  output logic                peie,
  output logic [CORE_SRC-1:0] en,
  output logic [CORE_SRC-1:0] flags,
  output logic                core_hit
);
  logic [CORE_SRC-1:0] flag_base;

  always_comb flag_base = we ? wdata[B_FL_HI:B_FL_LO] : flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie   <= 1'b0;
      peie  <= 1'b0;
      en    <= '0;
      flags <= '0;
    end else begin
      if (we) begin
        gie  <= wdata[B_GIE];
        peie <= wdata[B_PEIE];
        en   <= wdata[B_EN_HI:B_EN_LO];
      end
      if (ack) gie <= 1'b0;
      flags <= flag_base | evt;
    end
  end

  assign core_hit = |(flags & en);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flag_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] flags,
  output logic [W-1:0] ens,
  output logic         hit
);
  logic [W-1:0] base;

  always_comb base = flag_we ? wdata : flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      ens   <= '0;
    end else begin
      flags <= (base | evt) & MASK;
      if (en_we) ens <= wdata & MASK;
    end
  end

  assign hit = |(flags & ens);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int                PORT_W = 4,
  parameter logic [DATA_W-1:0] P1_MASK = 8'hFF,
  parameter logic [DATA_W-1:0] P2_MASK = 8'h59
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tmr_ovf_evt,
  input  logic              ext_edge_evt,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              port_rd,
  input  logic [DATA_W-1:0] per1_evt,
  input  logic [DATA_W-1:0] per2_evt,
  input  logic              irq_ack,
  output logic              irq_req
);
  localparam int NBANK = 2;
  localparam logic [NBANK*DATA_W-1:0] BANK_MASKS = {P2_MASK, P1_MASK};

  logic                gie_q, peie_q, core_hit, pc_mismatch;
  logic [CORE_SRC-1:0] core_en_q, core_flag_q;
  logic [PORT_W-1:0]   pc_ref;
  logic [DATA_W-1:0]   bank_evt   [NBANK];
  logic [DATA_W-1:0]   bank_flags [NBANK];
  logic [DATA_W-1:0]   bank_ens   [NBANK];
  logic [NBANK-1:0]    bank_hit;
  logic [DATA_W-1:0]   rd_mux;

  irq_port_change #(.W(PORT_W)) u_pchg (
    .clk(clk), .rst(rst), .pins(port_pins), .rd_strobe(port_rd),
    .ref_q(pc_ref), .mismatch(pc_mismatch)
  );

  irq_core_reg u_core (
    .clk(clk), .rst(rst),
    .we(reg_we && reg_addr == A_CORE),
    .wdata(reg_wdata), .ack(irq_ack),
    .evt({tmr_ovf_evt, ext_edge_evt, pc_mismatch}),
    .gie(gie_q), .peie(peie_q), .en(core_en_q), .flags(core_flag_q),
    .core_hit(core_hit)
  );

  assign bank_evt[0] = per1_evt;
  assign bank_evt[1] = per2_evt;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    irq_flag_bank #(
      .W(DATA_W),
      .MASK(BANK_MASKS[g*DATA_W +: DATA_W])
    ) u_bank (
      .clk(clk), .rst(rst),
      .flag_we(reg_we && reg_addr == A_PFLAG + ADDR_W'(g)),
      .en_we(reg_we && reg_addr == A_PEN + ADDR_W'(g)),
      .wdata(reg_wdata), .evt(bank_evt[g]),
      .flags(bank_flags[g]), .ens(bank_ens[g]), .hit(bank_hit[g])
    );
  end

  always_comb begin
    case (reg_addr)
      A_CORE:      rd_mux = {gie_q, peie_q, core_en_q, core_flag_q};
      A_PFLAG:     rd_mux = bank_flags[0];
      A_PFLAG + 1: rd_mux = bank_flags[1];
      A_PEN:       rd_mux = bank_ens[0];
      A_PEN + 1:   rd_mux = bank_ens[1];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq_req = gie_q && (core_hit || (peie_q && |bank_hit));
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       tmr_ovf_evt,
  input logic       irq_ack,
  input logic       irq_req,
  input logic       gie,
  input logic       peie,
  input logic       core_hit,
  input logic       pc_mismatch,
  input logic [2:0] core_flags,
  input logic [7:0] p2_flags,
  input logic [7:0] p2_ens
);
  // R9: acknowledge clears the master enable
  p_ack_clears_gie_r9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !gie);

  // R3: no request without the master enable
  p_req_needs_gie_r3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> gie);

  // R4: a request that no core source explains needs the group enable
  p_per_needs_peie_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !core_hit) |-> peie);

  // R2 / R10: a timer event always lands in its flag
  p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf_evt |=> core_flags[2]);

  // R5: a pin mismatch sets the port-change flag
  p_mismatch_sets_r5: assert property (@(posedge clk) disable iff (rst)
    pc_mismatch |=> core_flags[0]);

  // R7: a core flag falls only after a write to the core register
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (|($past(core_flags) & ~core_flags)) |-> $past(reg_we && reg_addr == 3'd0));

  // R8: unimplemented bits of bank 2 stay zero
  p_p2_mask_r8: assert property (@(posedge clk) disable iff (rst)
    ((p2_flags | p2_ens) & 8'hA6) == 8'h00);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .tmr_ovf_evt(tmr_ovf_evt), .irq_ack(irq_ack), .irq_req(irq_req),
  .gie(gie_q), .peie(peie_q), .core_hit(core_hit),
  .pc_mismatch(pc_mismatch), .core_flags(core_flag_q),
  .p2_flags(bank_flags[1]), .p2_ens(bank_ens[1])
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tmr_ovf_evt = 1'b0, ext_edge_evt = 1'b0;
  logic [3:0] port_pins = 4'h0;
  logic       port_rd = 1'b0;
  logic [7:0] per1_evt = 8'h00, per2_evt = 8'h00;
  logic       irq_ack = 1'b0;
  logic       irq_req;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_ovf_evt(tmr_ovf_evt), .ext_edge_evt(ext_edge_evt),
    .port_pins(port_pins), .port_rd(port_rd),
    .per1_evt(per1_evt), .per2_evt(per2_evt),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // {addr, write data, expected readback, expected irq_req}
  localparam logic [19:0] VEC [12] = '{
    {3'd3, 8'hA5, 8'hA5, 1'b0},  // R2 enable write
    {3'd1, 8'h04, 8'h04, 1'b0},  // R3 flag+enable, no master enable
    {3'd0, 8'h80, 8'h80, 1'b0},  // R4 master on, group off
    {3'd0, 8'hC0, 8'hC0, 1'b1},  // R4 group on
    {3'd1, 8'h00, 8'h00, 1'b0},  // R3 flag cleared
    {3'd2, 8'hFF, 8'h59, 1'b0},  // R8 mask on flags
    {3'd4, 8'hFF, 8'h59, 1'b1},  // R8 mask on enables, R3
    {3'd2, 8'h00, 8'h00, 1'b0},  // R3
    {3'd0, 8'hA4, 8'hA4, 1'b1},  // R3 core timer source
    {3'd0, 8'h94, 8'h94, 1'b0},  // R3 enable on other source
    {3'd0, 8'h00, 8'h00, 1'b0},  // R3
    {3'd5, 8'hFF, 8'h00, 1'b0}   // R11 unmapped
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", {7'd0, irq_req}, 8'h00);
    chk("R1 rdata during reset", reg_rdata, 8'h00);
    rst = 1'b0;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register after reset", v, 8'h00);
    end

    // vector table
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][19:17], VEC[i][16:9]);
      chk("R3 irq vector", {7'd0, irq_req}, {7'd0, VEC[i][0]});
      rd(VEC[i][19:17], v);
      chk("R11 readback vector", v, VEC[i][8:1]);
    end
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);

    // R2: events set flags with all enables off
    @(negedge clk);
    tmr_ovf_evt = 1'b1; per1_evt = 8'h40;
    @(negedge clk);
    tmr_ovf_evt = 1'b0; per1_evt = 8'h00;
    chk("R2 irq stays low", {7'd0, irq_req}, 8'h00);
    rd(3'd0, v); chk("R2 core timer flag", v, 8'h04);
    rd(3'd1, v); chk("R2 peripheral flag", v, 8'h40);

    // R7: flags persist
    repeat (10) @(negedge clk);
    rd(3'd0, v); chk("R7 flag persists", v, 8'h04);

    // R10: event and clearing write in the same cycle
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 8'h00; reg_we = 1'b1; tmr_ovf_evt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tmr_ovf_evt = 1'b0;
    rd(3'd0, v); chk("R10 event beats clear", v, 8'h04);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R7 clear by write", v, 8'h00);

    // R8: unimplemented bank-2 events ignored
    @(negedge clk);
    per2_evt = 8'hFF;
    @(negedge clk);
    per2_evt = 8'h00;
    rd(3'd2, v); chk("R8 bank2 event mask", v, 8'h59);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h00);

    // R5: persistent mismatch re-sets flag
    @(negedge clk);
    port_pins = 4'b0101;
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R5 mismatch sets flag", v, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R5 flag re-set while mismatch", v, 8'h01);

    // R6: port read ends mismatch
    @(negedge clk);
    port_rd = 1'b1;
    @(negedge clk);
    port_rd = 1'b0;
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R6 clear sticks after port read", v, 8'h00);
    @(negedge clk);
    port_pins = 4'b0100;
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R6 new change sets flag", v, 8'h01);
    @(negedge clk);
    port_rd = 1'b1;
    @(negedge clk);
    port_rd = 1'b0;
    wr(3'd0, 8'h00);

    // R9: acknowledge clears master enable
    wr(3'd0, 8'hA4);
    chk("R9 request before ack", {7'd0, irq_req}, 8'h01);
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R9 request after ack", {7'd0, irq_req}, 8'h00);
    rd(3'd0, v); chk("R9 master enable cleared", v, 8'h24);

    // R9: ack beats a write setting the master enable
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 8'hB4; reg_we = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; irq_ack = 1'b0;
    chk("R9 no request after ack+write", {7'd0, irq_req}, 8'h00);
    rd(3'd0, v); chk("R9 ack wins over write", v, 8'h34);

    // R11: read latency, data appears one edge after address
    @(negedge clk);
    reg_addr = 3'd7;
    @(negedge clk);
    chk("R11 unmapped reads zero", reg_rdata, 8'h00);
    reg_addr = 3'd0;
    @(negedge clk);
    chk("R11 data one edge after address", reg_rdata, 8'h34);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule